// File: doc/BRIEF.md
# Clock Bank Mode and Synchronous Stop Controller

This block sits after the skew-tap stage of a clock driver. It receives one undivided phase clock per output pair and the reference-phase clock, and from these it builds the final pair outputs. Each pair has a 3-level select. The third and fourth pairs can reuse that select to divide the reference by 2 or by 4, and the fourth pair can invert its phase clock instead. A polarity select chooses whether the dividers step on the rising or on the falling reference edge. It also sets the level at which stopped outputs rest.

A synchronous stop control freezes every pair except the second one. The second pair keeps toggling so that it can be routed back as the loop feedback. When the test level is MID and the stop control is asserted, the stop becomes per bank instead: only banks whose select is LL are frozen, and the rest run with their normal settings. A bank starts or stops only in a cycle where its output already sits at the stop level, so no runt pulses appear. All inputs are sampled by an oversampling clock `clk`, and every output is registered once. The stop input is active high, which makes LOW the enabled state. At board level it is pulled low and the polarity select is pulled high when left undriven.

Top module: `clkbank_ctl`

## Requirements
- R1: Each 3-level digit is coded on two bits: 00 LOW, 01 MID, 10 HIGH, and 11 is read as MID. A pair select is four bits `{digit1,digit0}`, with pair p (p = 0..3 for pairs 1..4) at bits `[4p+3:4p]`. With polarity HIGH and code LL (0000) on pair 3 or pair 4, that output is the reference divided by 2. It goes high on the first active edge after reset.
- R2: Code HH (1010) on pair 3 gives the reference divided by 4. The output is high for counts 1 and 2 of a 2-bit active-edge counter, where count 0 is the reset value.
- R3: Code HH on pair 4 gives the inverse of that pair's phase clock.
- R4: Any other code on any pair, and every code on pairs 1 and 2, copies the pair's phase clock to both outputs of the pair, delayed by one clock.
- R5: The dividers advance only on a rising reference edge when polarity is HIGH, and only on a falling edge when polarity is LOW.
- R6: Every rising edge of the divide-by-4 output falls in the same cycle as a rising edge of the divide-by-2 output. This holds from the first active edge after reset, because both share one counter.
- R7: With stop HIGH and the test level not MID, pairs 1, 3 and 4 are held at LOW when polarity is HIGH and at HIGH when polarity is LOW. Pair 2 keeps following its phase clock.
- R8: A stopped pair 4 in inverted mode rests at the polarity level: HIGH for polarity HIGH, LOW for polarity LOW.
- R9: With the test level MID and stop HIGH, exactly the banks whose select is LL are stopped, pair 2 included, and all other banks run normally. With the test level MID and stop LOW, nothing is stopped.
- R10: A bank changes between running and stopped only in a cycle where its unstopped value equals its stop level, so that its output shows no shortened pulse.
- R11: While reset is held, all outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ph | input | 1 | Reference-phase clock (sampled) |
| pair_ph | input | 4 | Undivided phase clock per pair |
| pair_sel | input | 16 | Two 3-level digits per pair |
| pol_rise | input | 1 | 1: rising-edge alignment, 0: falling |
| oe_stop | input | 1 | Synchronous stop request, active high |
| test_lvl | input | 2 | 3-level test input |
| bank_q | output | 8 | Two outputs per pair, pair p at bits [2p+1:2p] |

## Verification
The assertions check on every cycle several properties that are local to the design. The divider counter moves only on the active reference edge. Divide-by-4 rises only together with divide-by-2. A bank changes its run state only at its stop level and stays at that level while stopped. Pair 2 keeps following its phase clock whenever it is not being stopped. The bench scenarios are needed for the rest: the mapping from every select code to a mode across polarities, stop states and test levels, the exact stop levels, and the per-bank behaviour in test MID. Those are covered by sweeping all nine codes against a bench model with several reference periods.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

   typedef enum logic [1:0] {
      BM_PASS = 2'd0,
      BM_INV  = 2'd1,
      BM_DIV2 = 2'd2,
      BM_DIV4 = 2'd3
   } bank_mode_e;

   localparam int SEL_W = 4;

   // 3-level digit: 00 low, 01 mid, 10 high, 11 read as mid
   function automatic logic tl_mid(input logic [1:0] v);
      return v[0];
   endfunction

   function automatic logic sel_ll(input logic [SEL_W-1:0] s);
      return s == 4'b0000;
   endfunction

   function automatic logic sel_hh(input logic [SEL_W-1:0] s);
      return s == 4'b1010;
   endfunction

endpackage

// File: rtl/cbk_divider.sv
module cbk_divider (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_ph,
   input  logic       pol_rise,
   output logic [1:0] cnt_q,
   output logic       ref_q,
   output logic       half_clk,
   output logic       quarter_clk
);
   logic       ev;
   logic [1:0] cnt_n;

   always_comb begin
      ev          = pol_rise ? (ref_ph & ~ref_q) : (~ref_ph & ref_q);
      cnt_n       = cnt_q + {1'b0, ev};
      half_clk    = cnt_n[0];
      quarter_clk = cnt_n[0] ^ cnt_n[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         ref_q <= ref_ph;
      end
   end
endmodule

// File: rtl/cbk_mode_dec.sv
module cbk_mode_dec #(
   parameter int N_PAIR    = 4,
   parameter int FREE_PAIR = 1,
   parameter int DIVQ_PAIR = 2,
   parameter int INV_PAIR  = 3,
   localparam int SEL_BITS = N_PAIR * cbk_pkg::SEL_W
) (
   input  logic [SEL_BITS-1:0] pair_sel,
   input  logic [1:0]          test_lvl,
   input  logic                oe_stop,
   output cbk_pkg::bank_mode_e mode_o [N_PAIR],
   output logic [N_PAIR-1:0]   off_o
);
   import cbk_pkg::*;

   logic tmid;
   assign tmid = tl_mid(test_lvl);

   for (genvar b = 0; b < N_PAIR; b++) begin : g_bank
      logic [SEL_W-1:0] s;
      logic ll, hh;
      assign s  = pair_sel[b*SEL_W +: SEL_W];
      assign ll = sel_ll(s);
      assign hh = sel_hh(s);

      if (b == DIVQ_PAIR) begin : g_divq
         assign mode_o[b] = ll ? BM_DIV2 : (hh ? BM_DIV4 : BM_PASS);
      end else if (b == INV_PAIR) begin : g_inv
         assign mode_o[b] = ll ? BM_DIV2 : (hh ? BM_INV : BM_PASS);
      end else begin : g_plain
         assign mode_o[b] = BM_PASS;
      end

      if (b == FREE_PAIR) begin : g_free
         assign off_o[b] = tmid & oe_stop & ll;
      end else begin : g_stoppable
         assign off_o[b] = tmid ? (oe_stop & ll) : oe_stop;
      end
   end
endmodule

// File: rtl/cbk_bank_gate.sv
module cbk_bank_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic stop_lvl,
   input  logic off_req,
   output logic q,
   output logic run_q
);
   logic run_n;

   // run state may only move while the ungated value rests at stop level
   assign run_n = (raw == stop_lvl) ? ~off_req : run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b1;
         q     <= 1'b0;
      end else begin
         run_q <= run_n;
         q     <= run_n ? raw : stop_lvl;
      end
   end
endmodule

// File: rtl/clkbank_ctl.sv
module clkbank_ctl #(
   parameter int N_PAIR       = 4,
   parameter int OUT_PER_PAIR = 2,
   parameter int FREE_PAIR    = 1,
   parameter int DIVQ_PAIR    = 2,
   parameter int INV_PAIR     = 3,
   localparam int SEL_BITS    = N_PAIR * cbk_pkg::SEL_W,
   localparam int OUT_BITS    = N_PAIR * OUT_PER_PAIR
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_ph,
   input  logic [N_PAIR-1:0]   pair_ph,
   input  logic [SEL_BITS-1:0] pair_sel,
   input  logic                pol_rise,
   input  logic                oe_stop,
   input  logic [1:0]          test_lvl,
   output logic [OUT_BITS-1:0] bank_q
);
   import cbk_pkg::*;

   if (N_PAIR < 1 || OUT_PER_PAIR < 1) begin : g_bad_size
      $error("clkbank_ctl: pair count and outputs per pair must be positive");
   end
   if (FREE_PAIR >= N_PAIR || DIVQ_PAIR >= N_PAIR || INV_PAIR >= N_PAIR) begin : g_bad_idx
      $error("clkbank_ctl: special pair index out of range");
   end
   if (FREE_PAIR == DIVQ_PAIR || FREE_PAIR == INV_PAIR || DIVQ_PAIR == INV_PAIR) begin : g_bad_dup
      $error("clkbank_ctl: special pairs must be distinct");
   end

   bank_mode_e        mode [N_PAIR];
   logic [N_PAIR-1:0] bank_off;
   logic [N_PAIR-1:0] bank_raw;
   logic [N_PAIR-1:0] bank_stop;
   logic [N_PAIR-1:0] bank_run;
   logic [N_PAIR-1:0] bank_qi;
   logic [1:0]        div_cnt;
   logic              ref_prev;
   logic              half_clk;
   logic              quarter_clk;

   cbk_divider u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_ph      (ref_ph),
      .pol_rise    (pol_rise),
      .cnt_q       (div_cnt),
      .ref_q       (ref_prev),
      .half_clk    (half_clk),
      .quarter_clk (quarter_clk)
   );

   cbk_mode_dec #(
      .N_PAIR    (N_PAIR),
      .FREE_PAIR (FREE_PAIR),
      .DIVQ_PAIR (DIVQ_PAIR),
      .INV_PAIR  (INV_PAIR)
   ) u_dec (
      .pair_sel (pair_sel),
      .test_lvl (test_lvl),
      .oe_stop  (oe_stop),
      .mode_o   (mode),
      .off_o    (bank_off)
   );

   for (genvar b = 0; b < N_PAIR; b++) begin : g_bank
      always_comb begin
         unique case (mode[b])
            BM_INV:  bank_raw[b] = ~pair_ph[b];
            BM_DIV2: bank_raw[b] = half_clk;
            BM_DIV4: bank_raw[b] = quarter_clk;
            default: bank_raw[b] = pair_ph[b];
         endcase
         bank_stop[b] = (mode[b] == BM_INV) ? pol_rise : ~pol_rise;
      end

      cbk_bank_gate u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (bank_raw[b]),
         .stop_lvl (bank_stop[b]),
         .off_req  (bank_off[b]),
         .q        (bank_qi[b]),
         .run_q    (bank_run[b])
      );

      assign bank_q[b*OUT_PER_PAIR +: OUT_PER_PAIR] = {OUT_PER_PAIR{bank_qi[b]}};
   end
endmodule

// File: rtl/clkbank_ctl_chk.sv
module clkbank_ctl_chk #(
   parameter int N_PAIR    = 4,
   parameter int FREE_PAIR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_ph,
   input logic              pol_rise,
   input logic              free_ph,
   input logic [N_PAIR-1:0] bank_qi,
   input logic [N_PAIR-1:0] bank_run,
   input logic [N_PAIR-1:0] bank_stop,
   input logic [N_PAIR-1:0] bank_off,
   input logic [1:0]        div_cnt,
   input logic              ref_prev,
   input logic              half_clk,
   input logic              quarter_clk
);
   // R5: counter moves only on the selected reference edge
   a_r5_count_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_cnt) |->
         $past(pol_rise ? (ref_ph && !ref_prev) : (!ref_ph && ref_prev)));

   // R6: divide-by-4 rises only together with divide-by-2
   a_r6_div_align: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(quarter_clk) |-> $rose(half_clk));

   // R7: the feedback pair follows its phase clock while not being stopped
   a_r7_free_pair_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_run[FREE_PAIR] && !bank_off[FREE_PAIR]) |=>
         (bank_qi[FREE_PAIR] == $past(free_ph)));

   for (genvar b = 0; b < N_PAIR; b++) begin : g_bank
      // R10: run state switches only while output sits at stop level
      a_r10_switch_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(bank_run[b]) |-> (bank_qi[b] == $past(bank_stop[b])));

      // R7: a stopped bank rests at its stop level
      a_r7_stopped_level: assert property (@(posedge clk) disable iff (!rst_n)
         !bank_run[b] |-> (bank_qi[b] == $past(bank_stop[b])));
   end
endmodule

bind clkbank_ctl clkbank_ctl_chk #(
   .N_PAIR    (N_PAIR),
   .FREE_PAIR (FREE_PAIR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ref_ph      (ref_ph),
   .pol_rise    (pol_rise),
   .free_ph     (pair_ph[FREE_PAIR]),
   .bank_qi     (bank_qi),
   .bank_run    (bank_run),
   .bank_stop   (bank_stop),
   .bank_off    (bank_off),
   .div_cnt     (div_cnt),
   .ref_prev    (ref_prev),
   .half_clk    (half_clk),
   .quarter_clk (quarter_clk)
);

// File: tb/clkbank_ctl_test.sv
`timescale 1ns/1ps
module clkbank_ctl_test;
   localparam int NP  = 4;
   localparam int OPP = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ref_ph;
   logic [NP-1:0] pair_ph;
   logic [15:0]   pair_sel;
   logic          pol_rise;
   logic          oe_stop;
   logic [1:0]    test_lvl;
   logic [7:0]    bank_q;

   always #2 clk = ~clk;

   clkbank_ctl uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_ph   (ref_ph),
      .pair_ph  (pair_ph),
      .pair_sel (pair_sel),
      .pol_rise (pol_rise),
      .oe_stop  (oe_stop),
      .test_lvl (test_lvl),
      .bank_q   (bank_q)
   );

   int   total = 0;
   int   bad   = 0;
   bit   finished = 1'b0;
   int   t = 0;
   int   halfp = 4;
   logic [7:0]    hist = '0;
   logic [1:0]    m_cnt;
   logic          m_refp;
   logic [NP-1:0] m_run;
   logic [7:0]    prevq;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
      end
   endtask

   task automatic step(input bit do_r6);
      logic ev, h, qq, tmid, ll, hh, raw, stop, off, pr, e;
      int mode;
      string tag;
      @(negedge clk);
      hist   = {hist[6:0], ((t % (2*halfp)) < halfp)};
      t++;
      ref_ph  = hist[0];
      pair_ph = hist[3:0];
      @(posedge clk);
      ev = pol_rise ? (ref_ph & ~m_refp) : (~ref_ph & m_refp);
      m_cnt  = m_cnt + {1'b0, ev};
      m_refp = ref_ph;
      h  = m_cnt[0];
      qq = m_cnt[0] ^ m_cnt[1];
      tmid = test_lvl[0];
      #1;
      for (int b = 0; b < NP; b++) begin
         ll = (pair_sel[4*b +: 4] == 4'b0000);
         hh = (pair_sel[4*b +: 4] == 4'b1010);
         mode = 0;
         if (b == 2) mode = ll ? 2 : (hh ? 3 : 0);
         if (b == 3) mode = ll ? 2 : (hh ? 1 : 0);
         case (mode)
            1: raw = ~pair_ph[b];
            2: raw = h;
            3: raw = qq;
            default: raw = pair_ph[b];
         endcase
         stop = (mode == 1) ? pol_rise : ~pol_rise;
         off  = tmid ? (oe_stop & ll) : (oe_stop & (b != 1));
         pr   = m_run[b];
         if (raw == stop) m_run[b] = ~off;
         e = m_run[b] ? raw : stop;
         if (pr != m_run[b])            tag = "R10";
         else if (!m_run[b])            tag = (mode == 1) ? "R8" : (tmid ? "R9" : "R7");
         else if (mode == 2)            tag = pol_rise ? "R1" : "R5";
         else if (mode == 3)            tag = "R2";
         else if (mode == 1)            tag = "R3";
         else if (tmid && oe_stop)      tag = "R9";
         else if (oe_stop && b == 1)    tag = "R7";
         else                           tag = "R4";
         check(bank_q[2*b +: OPP] == {OPP{e}}, tag, int'(bank_q[2*b +: OPP]), int'({OPP{e}}));
      end
      if (do_r6 && bank_q[4] && !prevq[4])
         check(bank_q[6] && !prevq[6], "R6", int'(bank_q[6]), 1);
      prevq = bank_q;
   endtask

   initial begin
      rst_n    = 1'b0;
      ref_ph   = 1'b0;
      pair_ph  = '0;
      pol_rise = 1'b1;
      oe_stop  = 1'b0;
      test_lvl = 2'b00;
      pair_sel = {4'b0000, 4'b1010, 4'b0101, 4'b0000};
      repeat (4) @(posedge clk);
      #1;
      check(bank_q == 8'h00, "R11", int'(bank_q), 0);
      m_cnt  = '0;
      m_refp = 1'b0;
      m_run  = '1;
      prevq  = '0;
      rst_n  = 1'b1;

      // mixed banks: pair3 /4, pair4 /2, rising alignment
      for (int i = 0; i < 40; i++) step(1'b1);

      // sweep every code against polarity, stop and test level
      for (int code = 0; code < 9; code++) begin
         for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < 2; o++) begin
               for (int tl = 0; tl < 4; tl++) begin
                  logic [3:0] s4;
                  s4 = {2'(code / 3), 2'(code % 3)};
                  pair_sel = {4{s4}};
                  pol_rise = p[0];
                  oe_stop  = o[0];
                  test_lvl = 2'(tl);
                  halfp    = 3 + ((code + tl + o) % 3);
                  for (int i = 0; i < 16; i++) step(1'b0);
               end
            end
         end
      end

      // mixed banks with falling alignment and toggled stop
      pair_sel = {4'b0000, 4'b1010, 4'b0101, 4'b0000};
      pol_rise = 1'b0;
      test_lvl = 2'b00;
      halfp    = 4;
      for (int r = 0; r < 6; r++) begin
         oe_stop = r[0];
         for (int i = 0; i < 12; i++) step(!oe_stop);
      end

      // per-bank stop in test MID with mixed selects
      pair_sel = {4'b1010, 4'b0000, 4'b0000, 4'b1001};
      test_lvl = 2'b01;
      oe_stop  = 1'b1;
      pol_rise = 1'b1;
      for (int i = 0; i < 24; i++) step(1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule